// File: doc/BRIEF.md
# Paired Rising-Edge Detector

This block watches one single-bit input that is already synchronous to the clock and reports each 0-to-1 transition on it through two separate one-bit pulse outputs. Both pulses are produced by small state machines that share the clock, the reset and the input. One is an output-on-transition machine with two states. The other is an output-on-state machine with three states. They run side by side so that the one-cycle latency difference between the two styles can be observed directly at the ports.

The transition-based output reacts in the same cycle as the rising input, through a combinational path from the input. The state-based output comes from a register and rises one clock later. It has no combinational path from the input, so it can feed further logic without stretching a timing path. Reset is synchronous and active high. A 1 present on the input in the first cycle after reset is released counts as a rising edge.

Top module: `rise_detect_pair`

## Requirements
- R1: While `rst` is high, `rise_mealy` is 0. In every cycle that follows a clock edge at which `rst` was high, `rise_moore` is 0.
- R2: `rise_mealy` is 1 in the same cycle in which `sig_in` is 1, provided that `sig_in` was 0 in the previous cycle.
- R3: While `sig_in` stays at 1 for more than one cycle, `rise_mealy` is 0 in every cycle after the first.
- R4: `rise_mealy` is 0 in every cycle in which `sig_in` is 0.
- R5: `rise_moore` is 1 exactly in the cycle after each cycle in which `rise_mealy` was 1, and 0 in all other cycles.
- R6: Each rising edge gives exactly one single-cycle pulse on each output, however long `sig_in` then stays high.
- R7: When `sig_in` alternates 0,1,0,1 on consecutive cycles, each 1 gives a `rise_mealy` pulse in its own cycle and a `rise_moore` pulse one cycle later.
- R8: When `sig_in` is 1 in the first cycle after `rst` falls, that cycle counts as a rising edge. `rise_mealy` pulses in that cycle and `rise_moore` pulses in the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Monitored input, synchronous to clk |
| rise_mealy | output | 1 | Edge pulse from the two-state machine, in the same cycle as the edge |
| rise_moore | output | 1 | Edge pulse from the three-state machine, one cycle after the edge |

## Verification
`rise_mealy` is due in the same cycle as the input value that causes it. `rise_moore` is due one clock edge later, because only its state register stands between the input and the output. The bench changes `rst` and `sig_in` on the falling clock edge and samples both outputs 1 ns later, well before the next rising edge. Its reference therefore compares `rise_mealy` with the current input and the input of the previous cycle, and compares `rise_moore` with the `rise_mealy` value it expected one cycle earlier.

// File: rtl/rise_detect_pkg.sv
package rise_detect_pkg;

    // Two-state machine: has the input been seen low or high?
    typedef enum logic {
        MLY_LOW  = 1'b0,
        MLY_HIGH = 1'b1
    } mly_state_e;

    // Three-state machine: idle, pulse for one cycle, then hold while high
    typedef enum logic [1:0] {
        MOR_IDLE  = 2'd0,
        MOR_PULSE = 2'd1,
        MOR_HELD  = 2'd2
    } mor_state_e;

    // Result of one two-state-machine step: next state plus output
    typedef struct packed {
        mly_state_e nxt;
        logic       pulse;
    } mly_step_t;

    function automatic mly_step_t mly_step(input mly_state_e cur, input logic bit_in);
        mly_step_t r;
        r.nxt   = bit_in ? MLY_HIGH : MLY_LOW;
        r.pulse = bit_in && (cur == MLY_LOW);
        return r;
    endfunction

    function automatic mor_state_e mor_next(input mor_state_e cur, input logic bit_in);
        mor_state_e n;
        if (!bit_in) begin
            n = MOR_IDLE;
        end else begin
            case (cur)
                MOR_IDLE:  n = MOR_PULSE;
                MOR_PULSE: n = MOR_HELD;
                default:   n = MOR_HELD;
            endcase
        end
        return n;
    endfunction

    function automatic logic mor_output(input mor_state_e cur);
        return cur == MOR_PULSE;
    endfunction

endpackage

// File: rtl/rise_mealy_fsm.sv
module rise_mealy_fsm
    import rise_detect_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic pulse_o
);

    mly_state_e state_q;
    mly_step_t  step;

    always_comb begin
        step = mly_step(state_q, bit_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MLY_LOW;
        end else begin
            state_q <= step.nxt;
        end
    end

    // Combinational output, held low while reset is active
    assign pulse_o = step.pulse && !rst;

endmodule

// File: rtl/rise_moore_fsm.sv
module rise_moore_fsm
    import rise_detect_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic pulse_o
);

    mor_state_e state_q;
    mor_state_e state_d;

    always_comb begin
        state_d = mor_next(state_q, bit_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MOR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decoded from state only
    assign pulse_o = mor_output(state_q);

endmodule

// File: rtl/rise_detect_pair.sv
module rise_detect_pair (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise_mealy,
    output logic rise_moore
);

    rise_mealy_fsm u_mealy (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (sig_in),
        .pulse_o (rise_mealy)
    );

    rise_moore_fsm u_moore (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (sig_in),
        .pulse_o (rise_moore)
    );

endmodule

// File: rtl/rise_detect_pair_chk.sv
module rise_detect_pair_chk (
    input logic clk,
    input logic rst,
    input logic sig_in,
    input logic rise_mealy,
    input logic rise_moore
);

    // R1: transition-based output low while reset is held
    a_r1_mealy_low_in_reset: assert property (@(posedge clk)
        rst |-> !rise_mealy);

    // R1: state-based output low after any edge taken in reset
    a_r1_moore_low_after_reset: assert property (@(posedge clk)
        rst |=> !rise_moore);

    // R4: no transition-based pulse without the input high
    a_r4_mealy_needs_input: assert property (@(posedge clk) disable iff (rst)
        rise_mealy |-> sig_in);

    // R3: input held high across two running cycles gives no pulse
    a_r3_no_pulse_when_held: assert property (@(posedge clk) disable iff (rst)
        (sig_in && $past(sig_in) && !$past(rst)) |-> !rise_mealy);

    // R5: state-based pulse follows the transition-based pulse by one cycle
    a_r5_moore_follows: assert property (@(posedge clk) disable iff (rst)
        rise_mealy |=> rise_moore);

    // R5: state-based pulse only after a transition-based pulse
    a_r5_moore_has_cause: assert property (@(posedge clk) disable iff (rst)
        rise_moore |-> $past(rise_mealy));

    // R6: pulses never last two cycles
    a_r6_mealy_single: assert property (@(posedge clk) disable iff (rst)
        rise_mealy |=> !rise_mealy);

    a_r6_moore_single: assert property (@(posedge clk) disable iff (rst)
        rise_moore |=> !rise_moore);

endmodule

bind rise_detect_pair rise_detect_pair_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sig_in     (sig_in),
    .rise_mealy (rise_mealy),
    .rise_moore (rise_moore)
);

// File: tb/rise_detect_pair_tb_top.sv
`timescale 1ns/1ps
module rise_detect_pair_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_in = 1'b0;
    logic rise_mealy;
    logic rise_moore;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference state, built from the requirements
    logic prev_eff = 1'b0;     // input of previous cycle, 0 if that cycle was in reset
    logic prev_mly_exp = 1'b0; // transition-based pulse expected in the previous cycle

    always #4 clk = ~clk; // 125 MHz

    rise_detect_pair dut_i (
        .clk        (clk),
        .rst        (rst),
        .sig_in     (sig_in),
        .rise_mealy (rise_mealy),
        .rise_moore (rise_moore)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle, sample 1 ns after the falling edge, compare both outputs
    task automatic step(input logic r, input logic v, input string req);
        logic mly_exp;
        logic mor_exp;
        @(negedge clk);
        rst    = r;
        sig_in = v;
        #1;
        mly_exp = !r && v && !prev_eff;
        mor_exp = prev_mly_exp;
        check(req, "rise_mealy", rise_mealy, mly_exp);
        check(req, "rise_moore", rise_moore, mor_exp);
        prev_mly_exp = mly_exp;
        prev_eff     = r ? 1'b0 : v;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R1");
        step(1'b1, 1'b1, "R1");
        step(1'b1, 1'b0, "R1");
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, "R4");
    endtask

    task automatic t_single_edge;
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, "R4");
    endtask

    task automatic t_long_high;
        step(1'b0, 1'b1, "R2");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, "R6");
    endtask

    task automatic t_toggle;
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b0, "R7");
            step(1'b0, 1'b1, "R7");
        end
        step(1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, "R7");
    endtask

    task automatic t_high_out_of_reset;
        step(1'b0, 1'b1, "R8");
        step(1'b1, 1'b1, "R1");
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b1, "R8");
        step(1'b0, 1'b1, "R8");
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, "R4");
    endtask

    // Reset asserted in the cycle a transition-based pulse would follow
    task automatic t_reset_mid_pulse;
        step(1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, "R2");
        step(1'b1, 1'b1, "R1");
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, "R5");
    endtask

    task automatic t_mixed;
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, "R6");
        step(1'b0, 1'b0, "R6");
    endtask

    initial begin
        t_reset();
        t_single_edge();
        t_long_high();
        t_toggle();
        t_high_out_of_reset();
        t_reset_mid_pulse();
        t_mixed();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule